// File: doc/BRIEF.md
# Three-Wire Nibble Register Access Master

This block lets on-chip logic read and write the 4-bit registers of an external timekeeping device over a three-wire serial link: a serial clock, a data line with a separate output enable, and a serial input from the pad. The host raises a request with a read/write flag, a 4-bit register address and, for writes, 4-bit data. The block turns that into one or two command bytes, shifts them out most significant bit first and, for reads, shifts in one reply byte. It then gives a single-cycle completion pulse and, for reads, the low nibble of the reply.

Every byte on the wire carries a marker in its upper bits. A read sends `0x60 | addr` and then clocks in a reply byte. A write sends `0x20 | addr` and then `0x10 | data`. The serial clock rests high. Each bit spends one half period with the clock high and one with the clock low. The half period is set by a parameter in system clock cycles, so the 700 ns the device needs can be met at any system clock rate. The device's chip enable is driven by the caller and is not part of this block.

Top module: `nib3w_master`

## Requirements
- R1: Out of reset and whenever `busy_o` is low, `sclk_o` is high, `sdo_oe_o` is low and `done_o` is low.
- R2: A write access puts exactly two bytes on the wire, each as 8 clock low pulses, most significant bit first. The first byte is `0x20 | addr` and the second is `0x10 | wdata`.
- R3: A read access puts out the byte `0x60 | addr` with the output enable high. It then runs 8 more clock low pulses with `sdo_oe_o` low.
- R4: A read returns on `rdata_o` the last four bits received, MSB first. The upper four bits of the reply byte are dropped. Each bit is sampled, after a two-flop synchronizer, at the end of its clock-high half period.
- R5: Each clock low phase and each clock high phase inside a byte lasts exactly `HALF_CYC` system cycles (`HALF_CYC` >= 2).
- R6: `sdo_oe_o` rises only while `sclk_o` is high, with `sdo_o` already holding the first bit. It falls only at the rising clock edge that ends the eighth bit of a byte.
- R7: A request is accepted only when `busy_o` is low. `busy_o` is high from the cycle after acceptance until completion. A request raised while busy has no effect.
- R8: Completion is marked by `done_o` high for exactly one cycle, with `busy_o` already low in that cycle.
- R9: `sdo_o` changes only while `sclk_o` is high, never during a clock low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request, sampled when idle |
| rd_i | input | 1 | 1 = read access, 0 = write access |
| addr_i | input | 4 | Register address |
| wdata_i | input | 4 | Write data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 4 | Nibble returned by the last read |
| sclk_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the data line |
| sdi_i | input | 1 | Serial data in from the data pad (asynchronous) |

## Verification
A device model on the bench captures the data line at every falling clock edge and drives reply bits whose upper nibble differs from the lower one. A design that kept the wrong half of the reply, or sampled one bit late, returns a wrong nibble. Runs that put the address and data nibbles at all-ones and all-zeros expose a wrong marker bit or a swapped byte order. Phase lengths are measured directly, which catches an off-by-one half-period counter. The enable edges are checked against the clock and the bit count, which catches an enable raised before data is placed or dropped one bit early. A second request sent in the middle of a write must leave the wire stream and the completion count unchanged. A design that accepted it while busy would corrupt or lengthen the transfer.

// File: rtl/nib3w_pkg.sv
// Shared constants and state types for the three-wire nibble master.
// Assumes an 8-bit command byte whose upper nibble carries marker flags.
package nib3w_pkg;
    localparam int NIB_W  = 4;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] MARK_READ = 8'h40;
    localparam logic [BYTE_W-1:0] MARK_ADDR = 8'h20;
    localparam logic [BYTE_W-1:0] MARK_DATA = 8'h10;

    typedef enum logic [1:0] {SEQ_IDLE, SEQ_CMD, SEQ_TAIL} seq_t;
    typedef enum logic [1:0] {PH_IDLE, PH_HIGH, PH_LOW} phase_t;

    // Builds the address byte of an access from its nibble and direction.
    function automatic logic [BYTE_W-1:0] addr_byte(input logic rd, input logic [NIB_W-1:0] a);
        return MARK_ADDR | (rd ? MARK_READ : '0) | {{(BYTE_W-NIB_W){1'b0}}, a};
    endfunction
endpackage

// File: rtl/nib3w_halfper.sv
// Half-period timer: while run is high, expire pulses every HALF_CYC cycles.
// Assumes HALF_CYC >= 2; the count restarts from zero whenever run is low.
module nib3w_halfper #(
    parameter int HALF_CYC = 175
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt;

    assign expire = run && (cnt == CW'(HALF_CYC - 1));

    // Count cycles of the current phase, restarting at phase end or idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/nib3w_sync.sv
// Multi-flop synchronizer for one asynchronous input bit.
// Assumes the input is quasi-static over several system cycles.
module nib3w_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    assign q = chain[STAGES-1];

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end
endmodule

// File: rtl/nib3w_byte_eng.sv
// Byte engine: shifts one byte out (dir_in=0) or in (dir_in=1), MSB first.
// Each bit is a clock-high half period followed by a clock-low half period.
// Out data changes only at the clock rising edge or at start; input is
// sampled at the end of the high phase. Assumes start only while idle.
module nib3w_byte_eng #(
    parameter int HALF_CYC = 175,
    parameter int BITS     = 8,
    parameter int OUT_W    = 4,
    parameter int SYNC_N   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_in,
    input  logic [BITS-1:0]  load,
    input  logic             sdi_async,
    output logic             done,
    output logic [OUT_W-1:0] rx,
    output logic             sclk,
    output logic             sdo,
    output logic             oe
);
    import nib3w_pkg::*;

    localparam int BCW = (BITS > 1) ? $clog2(BITS) : 1;

    phase_t          ph;
    logic [BCW-1:0]  bitc;
    logic [BITS-1:0] shreg;
    logic            dir_q;
    logic            expire;
    logic            sdi_s;

    nib3w_halfper #(.HALF_CYC(HALF_CYC)) tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ph != PH_IDLE),
        .expire (expire)
    );

    nib3w_sync #(.STAGES(SYNC_N)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sdi_async),
        .q     (sdi_s)
    );

    assign sdo = dir_q ? 1'b0 : shreg[BITS-1];
    assign rx  = shreg[OUT_W-1:0];

    // Walk the high/low phases of each bit and shift the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph    <= PH_IDLE;
            bitc  <= '0;
            shreg <= '0;
            dir_q <= 1'b0;
            sclk  <= 1'b1;
            oe    <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        shreg <= load;
                        dir_q <= dir_in;
                        bitc  <= '0;
                        ph    <= PH_HIGH;
                    end
                end
                PH_HIGH: begin
                    if (!dir_q) begin
                        oe <= 1'b1;
                    end
                    if (expire) begin
                        if (dir_q) begin
                            shreg <= {shreg[BITS-2:0], sdi_s};
                        end
                        sclk <= 1'b0;
                        ph   <= PH_LOW;
                    end
                end
                PH_LOW: begin
                    if (expire) begin
                        sclk <= 1'b1;
                        if (bitc == BCW'(BITS - 1)) begin
                            ph   <= PH_IDLE;
                            oe   <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            bitc <= bitc + 1'b1;
                            ph   <= PH_HIGH;
                            if (!dir_q) begin
                                shreg <= {shreg[BITS-2:0], 1'b0};
                            end
                        end
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nib3w_master.sv
// Access sequencer: takes a host read/write request and runs the byte engine
// for the address byte, then either the data byte or a reply byte.
// Assumes the caller drives the device chip enable around each access.
module nib3w_master #(
    parameter int HALF_CYC = 175
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       rd_i,
    input  logic [3:0] addr_i,
    input  logic [3:0] wdata_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [3:0] rdata_o,
    output logic       sclk_o,
    output logic       sdo_o,
    output logic       sdo_oe_o,
    input  logic       sdi_i
);
    import nib3w_pkg::*;

    seq_t              st;
    logic              rd_q;
    logic [NIB_W-1:0]  wdata_q;
    logic              eng_start;
    logic              eng_dir;
    logic [BYTE_W-1:0] eng_load;
    logic              eng_done;
    logic [NIB_W-1:0]  eng_rx;

    assign busy_o = (st != SEQ_IDLE);

    // Choose the byte and direction for the next engine run.
    always_comb begin
        eng_start = ((st == SEQ_IDLE) && req_i) || ((st == SEQ_CMD) && eng_done);
        eng_dir   = (st == SEQ_CMD) && rd_q;
        if (st == SEQ_IDLE) begin
            eng_load = addr_byte(rd_i, addr_i);
        end else if (rd_q) begin
            eng_load = '0;
        end else begin
            eng_load = MARK_DATA | {{(BYTE_W-NIB_W){1'b0}}, wdata_q};
        end
    end

    nib3w_byte_eng #(
        .HALF_CYC (HALF_CYC),
        .BITS     (BYTE_W),
        .OUT_W    (NIB_W),
        .SYNC_N   (2)
    ) eng_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (eng_start),
        .dir_in    (eng_dir),
        .load      (eng_load),
        .sdi_async (sdi_i),
        .done      (eng_done),
        .rx        (eng_rx),
        .sclk      (sclk_o),
        .sdo       (sdo_o),
        .oe        (sdo_oe_o)
    );

    // Step through address byte and tail byte, then signal completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SEQ_IDLE;
            rd_q    <= 1'b0;
            wdata_q <= '0;
            done_o  <= 1'b0;
            rdata_o <= '0;
        end else begin
            done_o <= 1'b0;
            case (st)
                SEQ_IDLE: begin
                    if (req_i) begin
                        rd_q    <= rd_i;
                        wdata_q <= wdata_i;
                        st      <= SEQ_CMD;
                    end
                end
                SEQ_CMD: begin
                    if (eng_done) begin
                        st <= SEQ_TAIL;
                    end
                end
                SEQ_TAIL: begin
                    if (eng_done) begin
                        st     <= SEQ_IDLE;
                        done_o <= 1'b1;
                        if (rd_q) begin
                            rdata_o <= eng_rx;
                        end
                    end
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nib3w_master_chk.sv
// Property checker for the nibble master, attached by bind below.
// Assumes HALF_CYC matches the bound instance.
module nib3w_master_chk #(
    parameter int HALF_CYC = 175
) (
    input logic clk,
    input logic rst_n,
    input logic req_i,
    input logic busy_o,
    input logic done_o,
    input logic sclk_o,
    input logic sdo_o,
    input logic sdo_oe_o
);
    localparam int LCW = $clog2(HALF_CYC + 2);

    logic [LCW-1:0] low_cnt;

    // Count consecutive cycles with the serial clock low.
    always_ff @(posedge clk) begin
        if (!rst_n || sclk_o) begin
            low_cnt <= '0;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (sclk_o && !sdo_oe_o)); // R1
    AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> (low_cnt == LCW'(HALF_CYC))); // R5
    AST_OE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe_o) |-> (sclk_o && $stable(sdo_o))); // R6
    AST_OE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdo_oe_o) |-> sclk_o); // R6
    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(req_i)); // R7
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R8
    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_o) |-> sclk_o); // R9
endmodule

bind nib3w_master nib3w_master_chk #(.HALF_CYC(HALF_CYC)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .sclk_o   (sclk_o),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o)
);

// File: tb/nib3w_master_tb_top.sv
// Directed bench with a device model that captures the wire at clock falls.
module nib3w_master_tb_top;
    localparam int HALF = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic       rd_i = 1'b0;
    logic [3:0] addr_i = '0;
    logic [3:0] wdata_i = '0;
    logic       sdi_i = 1'b0;
    logic       busy_o, done_o, sclk_o, sdo_o, sdo_oe_o;
    logic [3:0] rdata_o;

    always #2 clk = ~clk;

    nib3w_master #(.HALF_CYC(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .rd_i(rd_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .busy_o(busy_o),
        .done_o(done_o), .rdata_o(rdata_o), .sclk_o(sclk_o),
        .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .sdi_i(sdi_i)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int nfall = 0, nrise = 0, base_fall = 0, base_rise = 0;
    int ndone = 0, dbl_done = 0, oe_bad = 0;
    int run_low = 0, run_hi = 0, last_low = 0, last_hi = 0;
    logic cap_sdo [0:31];
    logic cap_oe  [0:31];
    logic [7:0] slave_byte = 8'h00;
    logic prev_sclk = 1'b1, prev_oe = 1'b0, prev_sdo = 1'b0, prev_done = 1'b0;

    // Device model: capture wire, measure phases, present reply bits.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_sclk && !sclk_o) begin
                if (nfall - base_fall < 32) begin
                    cap_sdo[nfall - base_fall] = sdo_o;
                    cap_oe[nfall - base_fall]  = sdo_oe_o;
                end
                nfall   = nfall + 1;
                last_hi = run_hi;
            end
            if (!prev_sclk && sclk_o) begin
                nrise    = nrise + 1;
                last_low = run_low;
            end
            if (sclk_o) begin
                run_hi  = prev_sclk ? run_hi + 1 : 1;
                run_low = 0;
            end else begin
                run_low = prev_sclk ? 1 : run_low + 1;
                run_hi  = 0;
            end
            if (!prev_oe && sdo_oe_o && (!sclk_o || sdo_o != prev_sdo)) oe_bad = oe_bad + 1;
            if (prev_oe && !sdo_oe_o && (!sclk_o || ((nrise - base_rise) % 8) != 0 || nrise == base_rise))
                oe_bad = oe_bad + 1;
            if (done_o) begin
                ndone = ndone + 1;
                if (prev_done) dbl_done = dbl_done + 1;
            end
            begin
                int k;
                k = nfall - base_fall - 8;
                if (k < 0) k = 0;
                if (k > 7) k = 7;
                sdi_i = slave_byte[7 - k];
            end
            prev_sclk = sclk_o;
            prev_oe   = sdo_oe_o;
            prev_sdo  = sdo_o;
            prev_done = done_o;
        end
    end

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] cap_byte(input int off);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[7 - i] = cap_sdo[off + i];
        return b;
    endfunction

    task automatic wait_done();
        int t = 0;
        while (!done_o && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check(done_o, "R8 completion timeout", t, 0);
    endtask

    task automatic issue(input logic rd, input logic [3:0] a, input logic [3:0] d, input logic [7:0] sb);
        base_fall  = nfall;
        base_rise  = nrise;
        slave_byte = sb;
        @(negedge clk);
        req_i = 1'b1; rd_i = rd; addr_i = a; wdata_i = d;
        @(negedge clk);
        req_i = 1'b0;
        check(busy_o == 1'b1, "R7 busy after accept", busy_o, 1);
    endtask

    task automatic finish_checks(input int d0);
        check(busy_o == 1'b0, "R8 busy low at done", busy_o, 0);
        @(negedge clk);
        check(done_o == 1'b0, "R8 done one cycle", done_o, 0);
        check(ndone - d0 == 1 && dbl_done == 0, "R8 done count", ndone - d0, 1);
        check(sclk_o && !sdo_oe_o, "R1 line idle after access", {sclk_o, sdo_oe_o}, 2);
        check(nfall - base_fall == 16, "R2 clock pulse count", nfall - base_fall, 16);
        check(last_low == HALF, "R5 low phase length", last_low, HALF);
        check(last_hi == HALF, "R5 high phase length", last_hi, HALF);
        check(oe_bad == 0, "R6 enable edge placement", oe_bad, 0);
    endtask

    task automatic t_write(input logic [3:0] a, input logic [3:0] d);
        int d0 = ndone;
        bit oe_all = 1'b1;
        issue(1'b0, a, d, 8'h00);
        wait_done();
        check(cap_byte(0) == (8'h20 | {4'h0, a}), "R2 address byte", cap_byte(0), 8'h20 | a);
        check(cap_byte(8) == (8'h10 | {4'h0, d}), "R2 data byte", cap_byte(8), 8'h10 | d);
        for (int i = 0; i < 16; i++) if (!cap_oe[i]) oe_all = 1'b0;
        check(oe_all, "R6 enable high on write bits", oe_all, 1);
        finish_checks(d0);
    endtask

    task automatic t_read(input logic [3:0] a, input logic [7:0] sb);
        int d0 = ndone;
        bit oe_ok = 1'b1;
        issue(1'b1, a, 4'h0, sb);
        wait_done();
        check(rdata_o == sb[3:0], "R4 read nibble", rdata_o, sb[3:0]);
        check(cap_byte(0) == (8'h60 | {4'h0, a}), "R3 read command byte", cap_byte(0), 8'h60 | a);
        for (int i = 0; i < 8; i++) if (!cap_oe[i] || cap_oe[8 + i]) oe_ok = 1'b0;
        check(oe_ok, "R3 enable high on command, low on reply", oe_ok, 1);
        finish_checks(d0);
    endtask

    task automatic t_busy_ignore();
        int d0 = ndone;
        issue(1'b0, 4'h6, 4'hC, 8'h00);
        repeat (10) @(negedge clk);
        req_i = 1'b1; rd_i = 1'b1; addr_i = 4'hF;
        @(negedge clk);
        req_i = 1'b0;
        wait_done();
        check(cap_byte(0) == 8'h26, "R7 stray request left address byte", cap_byte(0), 8'h26);
        check(cap_byte(8) == 8'h1C, "R7 stray request left data byte", cap_byte(8), 8'h1C);
        finish_checks(d0);
        repeat (4) @(negedge clk);
        check(!busy_o && ndone - d0 == 1, "R7 no extra access", ndone - d0, 1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(sclk_o && !sdo_oe_o && !busy_o && !done_o, "R1 reset state",
              {sclk_o, sdo_oe_o, busy_o, done_o}, 4'b1000);
        check(!sdo_o, "R9 data quiet at reset", sdo_o, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write(4'h3, 4'h9);
        t_write(4'hF, 4'h0);
        t_write(4'h0, 4'hF);
        t_read(4'hA, 8'hA5);
        t_read(4'h0, 8'h3C);
        t_read(4'h5, 8'hF0);
        t_busy_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule